// File: doc/BRIEF.md
# Shared-Bus Control Latch Bank

This block holds three independent control latches that all load from one 2-bit enable bus. Each latch has its own active-high load strobe. While a strobe is high its latch is open, and the outputs follow the bus. When the strobe drops, the latch keeps the bus value present at that moment. The first latch drives the two serial-driver enables. The second drives the transmit and receive self-test enables, with inverted sense: a bus bit of 0 selects test mode. The third uses bus bit 0 only and drives the receiver power enable.

An active-low reset puts each latch into a safe state, but the rules differ. The driver-enable latch is cleared unconditionally. The self-test and receiver-power latches are cleared only while their strobes are low. The block also produces an active-low link-fault flag. It merges three receiver status inputs with the receiver-power state, so powering the receiver down raises a fault at once.

A parameter chooses the storage. The default is level-sensitive latches. The alternative is clocked flops fed by synchronised copies of the bus, strobes and reset, which add a fixed latency in clock cycles.

Top module: `shared_latch_bank`

## Requirements
- R1: While `oeStb` is high and reset is inactive, `drvAEn` equals bus bit 0 and `drvBEn` equals bus bit 1. A value of 1 enables the driver.
- R2: After `oeStb` falls, both driver enables keep the bus value present at the fall, and later bus changes have no effect on them.
- R3: While `rstN` is low, both driver enables are 0, even when `oeStb` is high.
- R4: While `bistStb` is high, `bistTxEn` is the inverse of bus bit 0 and `bistRxEn` is the inverse of bus bit 1. A bus bit of 0 selects test generate or compare, and 1 selects normal operation.
- R5: After `bistStb` falls, both self-test enables keep their captured values while the bus changes.
- R6: While `rstN` is low and `bistStb` is low, both self-test enables are 0. While `bistStb` is high, reset has no effect and the outputs follow R4.
- R7: While `rxStb` is high, `rxPwrEn` equals bus bit 0, and bus bit 1 is ignored. After `rxStb` falls, `rxPwrEn` holds its value.
- R8: While `rstN` is low and `rxStb` is low, `rxPwrEn` is 0. While `rxStb` is high, reset has no effect on it.
- R9: `linkFaultN` is 0 whenever `freqErr`, `ampLow` or `densLow` is 1, or whenever `rxPwrEn` is 0. Otherwise it is 1.
- R10: When several strobes are high together, each open latch loads the same bus value under its own mapping, and no strobe has priority over another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flop variant and for checking |
| rstN | input | 1 | Active-low reset |
| busIn | input | 2 | Shared enable bus |
| oeStb | input | 1 | Driver-enable latch strobe, active high |
| bistStb | input | 1 | Self-test latch strobe, active high |
| rxStb | input | 1 | Receiver-power latch strobe, active high |
| freqErr | input | 1 | Received frequency out of range |
| ampLow | input | 1 | Signal amplitude below threshold |
| densLow | input | 1 | Transition density too low |
| drvAEn | output | 1 | Serial driver A enable |
| drvBEn | output | 1 | Serial driver B enable |
| bistTxEn | output | 1 | Transmit self-test enable |
| bistRxEn | output | 1 | Receive self-test enable |
| rxPwrEn | output | 1 | Receiver PLL and analog power enable |
| linkFaultN | output | 1 | Link fault, active low |

## Verification
The bench builds the block with its default parameters, which select the level-sensitive latch variant with no synchronisation latency. Every output can therefore be compared a few nanoseconds after each input change, in the same clock period. This makes it possible to test the exact cases where a strobe and reset interact: a strobe falling while reset is already low, reset held while a strobe is open, and all three strobes open together.

// File: rtl/latch_bank_pkg.sv
package latch_bank_pkg;
  localparam int BUS_W = 2;

  typedef struct packed {
    logic oeOpen;
    logic bistOpen;
    logic rxOpen;
    logic clrN;
  } latchStb_t;
endpackage

// File: rtl/latch_bank_ctrl.sv
module latch_bank_ctrl
  import latch_bank_pkg::*;
#(
  parameter bit USE_FLOPS   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oeStb,
  input  logic             bistStb,
  input  logic             rxStb,
  input  logic [BUS_W-1:0] busIn,
  output latchStb_t        stb,
  output logic [BUS_W-1:0] busOut
);
  localparam int RAW_W = BUS_W + 4;

  logic [RAW_W-1:0] rawIn;
  logic [RAW_W-1:0] rawOut;

  assign rawIn = {rstN, oeStb, bistStb, rxStb, busIn};

  generate
    if (USE_FLOPS) begin : g_sync
      logic [RAW_W-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk) begin
        chain[0] <= rawIn;
        for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      end
      assign rawOut = chain[SYNC_STAGES-1];
    end else begin : g_pass
      logic unusedClk;
      assign unusedClk = clk;
      assign rawOut    = rawIn;
    end
  endgenerate

  assign stb.clrN     = rawOut[BUS_W+3];
  assign stb.oeOpen   = rawOut[BUS_W+2];
  assign stb.bistOpen = rawOut[BUS_W+1];
  assign stb.rxOpen   = rawOut[BUS_W];
  assign busOut       = rawOut[BUS_W-1:0];
endmodule

// File: rtl/latch_bank_dp.sv
module latch_bank_dp
  import latch_bank_pkg::*;
#(
  parameter bit USE_FLOPS = 1'b0
) (
  input  logic             clk,
  input  latchStb_t        stb,
  input  logic [BUS_W-1:0] bus,
  input  logic             freqErr,
  input  logic             ampLow,
  input  logic             densLow,
  output logic             drvAEn,
  output logic             drvBEn,
  output logic             bistTxEn,
  output logic             bistRxEn,
  output logic             rxPwrEn,
  output logic             linkFaultN
);
  logic [BUS_W-1:0] oeQ;
  logic [BUS_W-1:0] bistQ;
  logic             rxQ;

  generate
    if (USE_FLOPS) begin : g_flop
      always_ff @(posedge clk) begin
        if (!stb.clrN)      oeQ <= '0;
        else if (stb.oeOpen) oeQ <= bus;
      end
      always_ff @(posedge clk) begin
        if (stb.bistOpen)   bistQ <= bus;
        else if (!stb.clrN) bistQ <= '1;
      end
      always_ff @(posedge clk) begin
        if (stb.rxOpen)     rxQ <= bus[0];
        else if (!stb.clrN) rxQ <= 1'b0;
      end
    end else begin : g_latch
      logic unusedClk;
      assign unusedClk = clk;
      always_latch begin
        if (!stb.clrN)      oeQ <= '0;
        else if (stb.oeOpen) oeQ <= bus;
      end
      always_latch begin
        if (stb.bistOpen)   bistQ <= bus;
        else if (!stb.clrN) bistQ <= '1;
      end
      always_latch begin
        if (stb.rxOpen)     rxQ <= bus[0];
        else if (!stb.clrN) rxQ <= 1'b0;
      end
    end
  endgenerate

  assign drvAEn     = oeQ[0];
  assign drvBEn     = oeQ[1];
  assign bistTxEn   = ~bistQ[0];
  assign bistRxEn   = ~bistQ[1];
  assign rxPwrEn    = rxQ;
  assign linkFaultN = ~(freqErr | ampLow | densLow | ~rxQ);
endmodule

// File: rtl/shared_latch_bank.sv
module shared_latch_bank
  import latch_bank_pkg::*;
#(
  parameter bit USE_FLOPS   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busIn,
  input  logic       oeStb,
  input  logic       bistStb,
  input  logic       rxStb,
  input  logic       freqErr,
  input  logic       ampLow,
  input  logic       densLow,
  output logic       drvAEn,
  output logic       drvBEn,
  output logic       bistTxEn,
  output logic       bistRxEn,
  output logic       rxPwrEn,
  output logic       linkFaultN
);
  latchStb_t        stb;
  logic [BUS_W-1:0] busQ;

  latch_bank_ctrl #(.USE_FLOPS(USE_FLOPS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .oeStb  (oeStb),
    .bistStb(bistStb),
    .rxStb  (rxStb),
    .busIn  (busIn),
    .stb    (stb),
    .busOut (busQ)
  );

  latch_bank_dp #(.USE_FLOPS(USE_FLOPS)) u_dp (
    .clk       (clk),
    .stb       (stb),
    .bus       (busQ),
    .freqErr   (freqErr),
    .ampLow    (ampLow),
    .densLow   (densLow),
    .drvAEn    (drvAEn),
    .drvBEn    (drvBEn),
    .bistTxEn  (bistTxEn),
    .bistRxEn  (bistRxEn),
    .rxPwrEn   (rxPwrEn),
    .linkFaultN(linkFaultN)
  );
endmodule

// File: rtl/latch_bank_chk.sv
module latch_bank_chk #(
  parameter bit USE_FLOPS = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busIn,
  input logic       oeStb,
  input logic       bistStb,
  input logic       rxStb,
  input logic       freqErr,
  input logic       ampLow,
  input logic       densLow,
  input logic       drvAEn,
  input logic       drvBEn,
  input logic       bistTxEn,
  input logic       bistRxEn,
  input logic       rxPwrEn,
  input logic       linkFaultN
);
  generate
    if (!USE_FLOPS) begin : g_chk
      AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
        oeStb |-> ({drvBEn, drvAEn} == busIn)); // R1
      AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!oeStb && $past(!oeStb) && $past(rstN)) |-> $stable({drvBEn, drvAEn})); // R2
      AST_BIST_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
        bistStb |-> ({bistRxEn, bistTxEn} == ~busIn)); // R4
      AST_BIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!bistStb && $past(!bistStb) && $past(rstN)) |-> $stable({bistRxEn, bistTxEn})); // R5
      AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
        rxStb |-> (rxPwrEn == busIn[0])); // R7
      AST_FAULT_PWR: assert property (@(posedge clk) disable iff (!rstN)
        !rxPwrEn |-> !linkFaultN); // R9
      AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
        (rxPwrEn && !freqErr && !ampLow && !densLow) |-> linkFaultN); // R9

      always @(posedge clk) begin
        if (!rstN) begin
          AST_OE_RESET: assert ({drvBEn, drvAEn} == 2'b00); // R3
          if (!bistStb) begin
            AST_BIST_RESET: assert ({bistRxEn, bistTxEn} == 2'b00); // R6
          end
          if (!rxStb) begin
            AST_RX_RESET: assert (!rxPwrEn); // R8
          end
        end
      end
    end
  endgenerate
endmodule

bind shared_latch_bank latch_bank_chk #(.USE_FLOPS(USE_FLOPS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busIn     (busIn),
  .oeStb     (oeStb),
  .bistStb   (bistStb),
  .rxStb     (rxStb),
  .freqErr   (freqErr),
  .ampLow    (ampLow),
  .densLow   (densLow),
  .drvAEn    (drvAEn),
  .drvBEn    (drvBEn),
  .bistTxEn  (bistTxEn),
  .bistRxEn  (bistRxEn),
  .rxPwrEn   (rxPwrEn),
  .linkFaultN(linkFaultN)
);

// File: tb/shared_latch_bank_tb.sv
module shared_latch_bank_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] busIn;
  logic       oeStb, bistStb, rxStb;
  logic       freqErr, ampLow, densLow;
  logic       drvAEn, drvBEn, bistTxEn, bistRxEn, rxPwrEn, linkFaultN;

  int nCompared = 0;
  int nMismatch = 0;

  always #10 clk = ~clk;

  shared_latch_bank u_dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .oeStb(oeStb), .bistStb(bistStb),
    .rxStb(rxStb), .freqErr(freqErr), .ampLow(ampLow), .densLow(densLow),
    .drvAEn(drvAEn), .drvBEn(drvBEn), .bistTxEn(bistTxEn), .bistRxEn(bistRxEn),
    .rxPwrEn(rxPwrEn), .linkFaultN(linkFaultN)
  );

  // Vector fields: rstN oe bist rx bus[1:0] freq amp dens | drv{B,A} tx rx pwr faultN
  localparam int NVEC = 21;
  localparam logic [14:0] VEC [NVEC] = '{
    15'b0_0_0_0_00_000_00_0_0_0_0, // reset state: R3 R6 R8
    15'b1_1_0_0_10_000_10_0_0_0_0, // R1 open, B only
    15'b1_1_0_0_01_000_01_0_0_0_0, // R1 open, A only
    15'b1_0_0_0_01_000_01_0_0_0_0, // R2 strobe falls
    15'b1_0_0_0_11_000_01_0_0_0_0, // R2 bus change ignored
    15'b1_0_1_0_10_000_01_1_0_0_0, // R4 tx test
    15'b1_0_1_0_01_000_01_0_1_0_0, // R4 rx test
    15'b1_0_0_0_01_000_01_0_1_0_0, // R5 strobe falls
    15'b1_0_0_0_00_000_01_0_1_0_0, // R5 bus change ignored
    15'b1_0_0_1_01_000_01_0_1_1_1, // R7 power on, R9 clear
    15'b1_0_0_1_10_000_01_0_1_0_0, // R7 bit1 ignored, R9 fault
    15'b1_0_0_1_11_000_01_0_1_1_1, // R7
    15'b1_0_0_0_11_000_01_0_1_1_1, // R7 strobe falls
    15'b1_0_0_0_00_000_01_0_1_1_1, // R7 hold
    15'b1_0_0_0_00_100_01_0_1_1_0, // R9 frequency
    15'b1_0_0_0_00_010_01_0_1_1_0, // R9 amplitude
    15'b1_0_0_0_00_001_01_0_1_1_0, // R9 density
    15'b1_0_0_0_00_000_01_0_1_1_1, // R9 clear
    15'b1_1_1_1_10_000_10_1_0_0_0, // R10 all open
    15'b1_1_1_1_11_000_11_0_0_1_1, // R10 all open
    15'b1_0_0_0_11_000_11_0_0_1_1  // R10 all close
  };

  task automatic check(input logic [5:0] act, input logic [5:0] exp, input string what);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic applyVec(input logic [14:0] v);
    rstN    = v[14];
    oeStb   = v[13];
    bistStb = v[12];
    rxStb   = v[11];
    busIn   = v[10:9];
    freqErr = v[8];
    ampLow  = v[7];
    densLow = v[6];
    #5;
    check({4'b0, drvBEn, drvAEn},     {4'b0, v[5:4]}, "drivers R1 R2 R3");
    check({4'b0, bistRxEn, bistTxEn}, {4'b0, v[2], v[3]}, "self-test R4 R5 R6");
    check({5'b0, rxPwrEn},            {5'b0, v[1]}, "rx power R7 R8");
    check({5'b0, linkFaultN},         {5'b0, v[0]}, "link fault R9");
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nMismatch++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVEC; i++) applyVec(VEC[i]);

    // Directed: reset against open strobes
    applyVec(15'b1_0_1_1_00_000_11_1_1_0_0); // R4 R7 open with bus 00
    applyVec(15'b0_0_1_1_00_000_00_1_1_0_0); // R3 clears drivers, R6 R8 no effect while open
    applyVec(15'b0_0_1_1_11_000_00_0_0_1_1); // R6 R8 still follow bus in reset
    applyVec(15'b0_0_0_0_11_000_00_0_0_0_0); // R6 R8 close under reset -> cleared
    applyVec(15'b0_1_0_0_11_000_00_0_0_0_0); // R3 reset beats open strobe
    applyVec(15'b1_1_0_0_11_000_11_0_0_0_0); // R1 reopens after reset

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule